// File: doc/BRIEF.md
# Four-Channel Flyby DMA Request Controller

This block is the control core of a four-channel flyby DMA engine. Software loads, for each channel, a 16-bit start address and a 16-bit count word through a simple write port. The count word carries a 14-bit cycle count and a 2-bit transfer type. A separate mode word sets the channel enables and picks fixed or rotating arbitration. Peripherals raise a request line. The block asks the CPU for the bus with a hold request, and waits for hold acknowledge. It then runs one-clock transfer cycles and grants one channel per cycle through an active-low acknowledge line.

During each cycle the block drives the low address byte on a dedicated output and puts the high address byte on the data-bus output. It pulses a strobe whenever an external latch must capture a new high byte. Each cycle advances the granted channel's address and count. When a channel's count runs out, the block flags terminal count and disables that channel. It releases the bus once no enabled request remains. Actual data movement, pads and wait states are handled outside this block.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hrq, aen, adstb and tc are low, every dack_n line is high, and all channels are disabled, so requests alone cause no hrq.
- R2: The write port decodes wr_addr as follows. Bit 3 set selects the mode word: wr_data[3:0] are the channel enables (bit n for channel n) and wr_data[4]=1 selects rotating priority. With bit 3 clear, wr_addr[2:1] is the channel; wr_addr[0]=0 loads its address and wr_addr[0]=1 loads its count word, whose bits [13:0] are the count and bits [15:14] the transfer type.
- R3: When an enabled channel requests, hrq rises on the next cycle. No transfer cycle (aen high) starts until hlda has been seen high.
- R4: A request on a disabled channel is ignored: it raises no hrq and gets no acknowledge.
- R5: In fixed mode, the lowest-numbered pending enabled channel wins: channel 0 is highest and channel 3 is lowest.
- R6: In rotating mode, the search starts at the channel after the one last serviced, so the just-serviced channel becomes the lowest priority.
- R7: A transfer cycle lasts one clock. In that clock aen is high, exactly one dack_n is low (the granted channel's), addr_lo carries address bits [7:0], db_out carries bits [15:8], and xfer_type carries the channel's type field.
- R8: After each cycle, the granted channel's address increases by one (modulo 2^16) and its count field decreases by one.
- R9: tc is high in the cycle where the granted channel's count field is zero, so a count of N yields N+1 cycles. That channel is then disabled, and hrq falls once no enabled request remains.
- R10: adstb pulses in a cycle exactly when it is the first cycle after gaining the bus, when the granted channel differs from the previous cycle's, or when the address low byte is 0x00 after a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select (see R2) |
| wr_data | input | 16 | Register write data |
| drq | input | 4 | Per-channel request lines |
| hlda | input | 1 | Hold acknowledge from CPU |
| hrq | output | 1 | Hold request to CPU |
| aen | output | 1 | High while the block owns the bus |
| adstb | output | 1 | High-byte latch strobe |
| dack_n | output | 4 | Active-low per-channel acknowledge |
| addr_lo | output | 8 | Address low byte |
| db_out | output | 8 | Address high byte on data bus |
| tc | output | 1 | Terminal count flag |
| xfer_type | output | 2 | Transfer type of granted channel |

## Verification
Every cycle, the assertions check that the acknowledges are one-hot and appear only with aen, that aen never appears without hrq and a prior hlda, that tc and adstb appear only inside transfer cycles, that the first cycle of bus ownership strobes, and that the address steps by one across consecutive unstrobed cycles on the same channel. Other properties depend on a history of writes and requests, so only the bench's scenarios can show them: the choice of winner under fixed and rotating arbitration, the exact number of cycles that a count produces, auto-disable at terminal count, and the correct transfer type and high byte. The bench sweeps every request mask in both priority modes against an arithmetic model.

// File: rtl/dma4_ctrl.sv
module dma4_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 2,
  localparam int TW  = AW - CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [AW-1:0]     wr_data,
  input  logic [NCH-1:0]    drq,
  input  logic              hlda,
  output logic              hrq,
  output logic              aen,
  output logic              adstb,
  output logic [NCH-1:0]    dack_n,
  output logic [7:0]        addr_lo,
  output logic [AW-9:0]     db_out,
  output logic              tc,
  output logic [TW-1:0]     xfer_type
);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} st_t;

  st_t              st_q;
  logic [AW-1:0]    addr_q [NCH];
  logic [CW-1:0]    cnt_q  [NCH];
  logic [TW-1:0]    typ_q  [NCH];
  logic [NCH-1:0]   en_q, en_eff, pend;
  logic             rot_q, was_xfer_q;
  logic [CHW-1:0]   gnt_q, last_q, last_n, start, idx, arb;
  logic [CHW-1:0]   wch;

  wire xfer   = (st_q == S_XFER);
  wire tc_now = xfer && (cnt_q[gnt_q] == '0);
  wire any    = |pend;
  assign wch  = wr_addr[CHW:1];

  always_comb begin
    en_eff = en_q;
    if (tc_now) en_eff[gnt_q] = 1'b0;
    pend   = drq & en_eff;
    last_n = xfer ? gnt_q : last_q;
    start  = rot_q ? last_n + 1'b1 : '0;
    arb    = '0;
    idx    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      idx = start + CHW'(i);
      if (pend[idx]) arb = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      en_q       <= '0;
      rot_q      <= 1'b0;
      gnt_q      <= '0;
      last_q     <= CHW'(NCH - 1);
      was_xfer_q <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        addr_q[c] <= '0;
        cnt_q[c]  <= '0;
        typ_q[c]  <= '0;
      end
    end else begin
      was_xfer_q <= xfer;
      case (st_q)
        S_IDLE: if (any) st_q <= S_HOLD;
        S_HOLD: begin
          if (!any) st_q <= S_IDLE;
          else if (hlda) begin
            st_q  <= S_XFER;
            gnt_q <= arb;
          end
        end
        S_XFER: begin
          if (!any) st_q <= S_IDLE;
          else if (hlda) gnt_q <= arb;
          else st_q <= S_HOLD;
        end
        default: st_q <= S_IDLE;
      endcase
      if (xfer) begin
        addr_q[gnt_q] <= addr_q[gnt_q] + 1'b1;
        cnt_q[gnt_q]  <= cnt_q[gnt_q] - 1'b1;
        last_q        <= gnt_q;
        if (tc_now) en_q[gnt_q] <= 1'b0;
      end
      if (wr_en) begin
        if (wr_addr[RAW-1]) begin
          en_q  <= wr_data[NCH-1:0];
          rot_q <= wr_data[NCH];
        end else if (wr_addr[0]) begin
          cnt_q[wch] <= wr_data[CW-1:0];
          typ_q[wch] <= wr_data[AW-1:CW];
        end else begin
          addr_q[wch] <= wr_data;
        end
      end
    end
  end

  assign hrq       = (st_q != S_IDLE);
  assign aen       = xfer;
  assign tc        = tc_now;
  assign dack_n    = xfer ? ~(NCH'(1) << gnt_q) : '1;
  assign addr_lo   = xfer ? addr_q[gnt_q][7:0] : '0;
  assign db_out    = xfer ? addr_q[gnt_q][AW-1:8] : '0;
  assign xfer_type = xfer ? typ_q[gnt_q] : '0;
  assign adstb     = xfer && (!was_xfer_q || gnt_q != last_q || addr_q[gnt_q][7:0] == 8'h00);

endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           hlda,
  input logic           hrq,
  input logic           aen,
  input logic           adstb,
  input logic           tc,
  input logic [NCH-1:0] dack_n,
  input logic [7:0]     addr_lo
);

  a_r7_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  a_r7_dack_with_aen: assert property (@(posedge clk) disable iff (!rst_n)
    aen == ($countones(~dack_n) == 1));

  a_r3_aen_after_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> $past(hlda));

  a_r3_aen_needs_hrq: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> hrq);

  a_r9_tc_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> aen);

  a_r10_stb_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> aen);

  a_r10_stb_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> adstb);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (aen && $past(aen) && !adstb && !$past(wr_en) && dack_n == $past(dack_n))
      |-> addr_lo == $past(addr_lo) + 8'd1);

endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hlda(hlda), .hrq(hrq),
  .aen(aen), .adstb(adstb), .tc(tc), .dack_n(dack_n), .addr_lo(addr_lo)
);

// File: tb/dma4_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma4_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  drq = 0;
  logic        hlda = 0, cpu_allow = 0;
  logic        hrq, aen, adstb, tc;
  logic [3:0]  dack_n;
  logic [7:0]  addr_lo, db_out;
  logic [1:0]  xfer_type;

  int n_chk = 0, n_fail = 0, xfers = 0;
  bit done = 0;

  logic [15:0] m_addr [4];
  logic [13:0] m_cnt  [4];
  logic [1:0]  m_typ  [4];
  logic [3:0]  m_en = 0;
  logic        m_rot = 0, m_prev_aen = 0;
  logic [1:0]  m_last = 2'd3;

  dma4_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .drq(drq), .hlda(hlda), .hrq(hrq), .aen(aen), .adstb(adstb), .dack_n(dack_n),
    .addr_lo(addr_lo), .db_out(db_out), .tc(tc), .xfer_type(xfer_type)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      hlda = hrq & cpu_allow;
    end
  end

  // reference model of arbitration and per-cycle outputs
  logic [3:0] pend;
  logic [1:0] g, st, ix;
  logic       e_stb, e_tc;
  always @(negedge clk) if (rst_n) begin
    if (aen) begin
      xfers++;
      pend = drq & m_en;
      st = m_rot ? m_last + 2'd1 : 2'd0;
      g = 0;
      for (int i = 3; i >= 0; i--) begin
        ix = st + 2'(i);
        if (pend[ix]) g = ix;
      end
      chk(dack_n == ~(4'd1 << g), m_rot ? "R6" : "R5", dack_n, ~(4'd1 << g));
      chk(addr_lo == m_addr[g][7:0], "R7", addr_lo, m_addr[g][7:0]);
      chk(db_out == m_addr[g][15:8], "R7", db_out, m_addr[g][15:8]);
      chk(xfer_type == m_typ[g], "R7", xfer_type, m_typ[g]);
      e_stb = !m_prev_aen || g != m_last || m_addr[g][7:0] == 8'h00;
      chk(adstb == e_stb, "R10", adstb, e_stb);
      e_tc = (m_cnt[g] == 0);
      chk(tc == e_tc, "R9", tc, e_tc);
      m_addr[g] = m_addr[g] + 16'd1;  // R8
      m_cnt[g]  = m_cnt[g] - 14'd1;
      if (e_tc) m_en[g] = 1'b0;
      m_last = g;
    end
    m_prev_aen = aen;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    if (a[3]) begin m_en = d[3:0]; m_rot = d[4]; end
    else if (a[0]) begin m_cnt[a[2:1]] = d[13:0]; m_typ[a[2:1]] = d[15:14]; end
    else m_addr[a[2:1]] = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic prog(input int ch, input logic [15:0] ad, input logic [1:0] ty, input logic [13:0] cn);
    wr(4'(ch * 2), ad);
    wr(4'(ch * 2 + 1), {ty, cn});
  endtask

  task automatic run(input logic [3:0] req, input int exp_x);
    int n = 0;
    int x0 = xfers;
    @(negedge clk); #1;
    drq = req;
    repeat (3) @(negedge clk);
    while (hrq && n < 300) begin @(negedge clk); n++; end
    chk(!hrq && n < 300, "R9", hrq, 0);
    chk(xfers - x0 == exp_x, "R9", xfers - x0, exp_x);
    #1; drq = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin m_addr[c] = 0; m_cnt[c] = 0; m_typ[c] = 0; end
    repeat (3) @(negedge clk);
    chk(!hrq && !aen && !tc && !adstb, "R1", {hrq, aen, tc, adstb}, 0);
    chk(dack_n == 4'hF, "R1", dack_n, 4'hF);
    #1; rst_n = 1; cpu_allow = 1; drq = 4'hF;
    repeat (4) @(negedge clk);
    chk(!hrq, "R1", hrq, 0);
    #1; drq = 0;

    // fixed priority, mixed counts and types, wraps in the low byte
    prog(0, 16'h12FE, 2'd1, 14'd2);
    prog(1, 16'h3400, 2'd2, 14'd1);
    prog(2, 16'h56FF, 2'd0, 14'd0);
    prog(3, 16'h7810, 2'd3, 14'd3);
    wr(4'h8, 16'h000F);
    run(4'hF, 10);

    // rotating priority
    for (int c = 0; c < 4; c++) prog(c, 16'(16'h2000 * c + 16'h00FD), 2'(c), 14'd2);
    wr(4'h8, 16'h001F);
    run(4'hF, 12);

    // hold acknowledge withheld
    cpu_allow = 0;
    prog(1, 16'hABCD, 2'd2, 14'd0);
    wr(4'h8, 16'h0002);
    @(negedge clk); #1; drq = 4'h2;
    repeat (6) @(negedge clk);
    chk(hrq == 1'b1, "R3", hrq, 1);
    chk(aen == 1'b0, "R3", aen, 0);
    #1; cpu_allow = 1;
    run(4'h2, 1);

    // disabled channels ignored
    wr(4'h8, 16'h0000);
    @(negedge clk); #1; drq = 4'hF;
    repeat (5) @(negedge clk);
    chk(!hrq && dack_n == 4'hF, "R4", {hrq, dack_n}, 4'hF);
    #1; drq = 0;
    wr(4'h8, 16'h0004);
    @(negedge clk); #1; drq = 4'h1;
    repeat (5) @(negedge clk);
    chk(!hrq, "R4", hrq, 0);
    #1; drq = 0;

    // sweep of every request mask in both modes (R2 decode via replayed addresses)
    for (int r = 0; r < 2; r++)
      for (int m = 1; m < 16; m++) begin
        for (int c = 0; c < 4; c++) prog(c, {4'(c), 4'(m), 8'hFF}, 2'(m + c), 14'd1);
        wr(4'h8, {11'd0, 1'(r), 4'hF});
        run(4'(m), 2 * $countones(4'(m)));
      end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule